// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the digital feedback divider of a frequency synthesizer. It divides its input clock by N = B·P + A. A dual-modulus prescaler divides by P+1 or by P. A swallow counter (A) and a main counter (B) drive its modulus control. A select input picks the narrow pair (P = 32, so 32/33) or the wide pair (P = 64, so 64/65). The output is a one-cycle pulse once every N input cycles, for a phase detector to compare against the reference.

Each output period starts with the prescaler dividing by P+1 while the swallow counter counts down. Once that counter reaches zero, the prescaler divides by P for the rest of the main count. Both counters reload when the main count runs out. New A, B and select values are taken only at that reload, so a period that has started always runs to completion with one consistent setting. A programmed B below A is flagged by a sticky error bit. The divider keeps running in that case.

Top module: `pswallow_divider`

## Requirements
- R1: With B ≥ A and B ≥ 1, consecutive output pulses are exactly B·P + A input cycles apart, where P = 32 when `sel_wide` = 0 and P = 64 when `sel_wide` = 1.
- R2: `div_pulse` is high for exactly one input cycle per output period.
- R3: The full A range 0..63 (6 bits) and B range 1..2047 (11 bits) is honoured, including the edge cases A = 0 and A = B.
- R4: A change to `a_val`, `b_val` or `sel_wide` made during a period leaves that period's length unchanged. The new setting governs the period that begins at the next output pulse.
- R5: If the active setting has B < A, `cfg_err` goes high one cycle later and stays high until `rst`, even after a valid setting is loaded. The output stays periodic with period B·(P+1).
- R6: While `rst` is high, `div_pulse` and `cfg_err` are low and the setting on the inputs is captured. The first pulse is seen after the N-th rising edge that follows the last reset edge.
- R7: B = 0 is treated as B = 1, so with A = 0 the period is P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous active-high reset, also captures the setting |
| sel_wide | input | 1 | Prescaler pair: 0 = 32/33, 1 = 64/65 |
| a_val | input | 6 | Swallow count A |
| b_val | input | 11 | Main count B |
| div_pulse | output | 1 | Registered one-cycle pulse per N input cycles |
| cfg_err | output | 1 | Sticky flag: an active setting had B < A |

## Verification
The assertions check the following on every cycle:
- a pulse never lasts longer than one cycle;
- no period is ever shorter than the narrow modulus;
- the error bit follows an active B < A setting and never drops outside reset;
- reset silences the output.

The exact period B·P + A, the deferred take-up of a new setting at the reload boundary, the B = 0 and A = B edge cases, and the B·(P+1) period under a bad setting can only be shown by the bench's scenarios. These scenarios measure pulse spacing for a spread of (P, A, B) settings.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  typedef enum logic {
    PSEL_NARROW = 1'b0,
    PSEL_WIDE   = 1'b1
  } psel_e;
endpackage

// File: rtl/pswallow_cfg_shadow.sv
module pswallow_cfg_shadow
  import pswallow_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 11
) (
  input  logic           clk,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  psel_e          sel_in,
  output logic [A_W-1:0] a_act,
  output logic [B_W-1:0] b_act,
  output logic [A_W-1:0] a_nxt,
  output logic [B_W-1:0] b_nxt,
  output psel_e          sel_nxt
);
  psel_e sel_act;

  // Value that the counters take on the load edge: fresh inputs at a boundary.
  always_comb begin
    if (load) begin
      a_nxt   = a_in;
      b_nxt   = b_in;
      sel_nxt = sel_in;
    end else begin
      a_nxt   = a_act;
      b_nxt   = b_act;
      sel_nxt = sel_act;
    end
  end

  always_ff @(posedge clk) begin
    a_act   <= a_nxt;
    b_act   <= b_nxt;
    sel_act <= sel_nxt;
  end
endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler
  import pswallow_pkg::*;
#(
  parameter int P_NARROW = 32,
  parameter int P_WIDE   = 64
) (
  input  logic  clk,
  input  logic  rst,
  input  psel_e sel_nxt,
  input  logic  mc_nxt,
  output logic  tick
);
  localparam int CW = $clog2(P_WIDE + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] base;
  logic [CW-1:0] reload_val;

  // Modulus control high selects P+1: a count of P down to 0.
  always_comb begin
    base       = (sel_nxt == PSEL_WIDE) ? CW'(P_WIDE) : CW'(P_NARROW);
    reload_val = mc_nxt ? base : base - CW'(1);
  end

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || tick) cnt <= reload_val;
    else             cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/pswallow_swallow.sv
module pswallow_swallow #(
  parameter int A_W = 6
) (
  input  logic           clk,
  input  logic           load,
  input  logic           tick,
  input  logic [A_W-1:0] a_nxt,
  output logic           mc_nxt
);
  logic [A_W-1:0] a_cnt;

  // Modulus control for the prescaler period that starts after this edge.
  always_comb begin
    if (load)      mc_nxt = (a_nxt != '0);
    else if (tick) mc_nxt = (a_cnt > A_W'(1));
    else           mc_nxt = (a_cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (load)                      a_cnt <= a_nxt;
    else if (tick && a_cnt != '0)  a_cnt <= a_cnt - A_W'(1);
  end
endmodule

// File: rtl/pswallow_main.sv
module pswallow_main #(
  parameter int B_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [B_W-1:0] b_nxt,
  output logic           expire
);
  logic [B_W-1:0] b_cnt;

  // Zero and one both end on the first prescaler period.
  assign expire = tick && (b_cnt <= B_W'(1));

  always_ff @(posedge clk) begin
    if (rst || expire) b_cnt <= b_nxt;
    else if (tick)     b_cnt <= b_cnt - B_W'(1);
  end
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
  import pswallow_pkg::*;
#(
  parameter int A_W      = 6,
  parameter int B_W      = 11,
  parameter int P_NARROW = 32,
  parameter int P_WIDE   = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel_wide,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  output logic           div_pulse,
  output logic           cfg_err
);
  logic           tick;
  logic           expire;
  logic           boundary;
  logic           mc_nxt;
  logic [A_W-1:0] act_a;
  logic [B_W-1:0] act_b;
  logic [A_W-1:0] a_nxt;
  logic [B_W-1:0] b_nxt;
  psel_e          sel_nxt;

  assign boundary = rst || expire;

  pswallow_cfg_shadow #(.A_W(A_W), .B_W(B_W)) u_shadow (
    .clk    (clk),
    .load   (boundary),
    .a_in   (a_val),
    .b_in   (b_val),
    .sel_in (psel_e'(sel_wide)),
    .a_act  (act_a),
    .b_act  (act_b),
    .a_nxt  (a_nxt),
    .b_nxt  (b_nxt),
    .sel_nxt(sel_nxt)
  );

  pswallow_prescaler #(.P_NARROW(P_NARROW), .P_WIDE(P_WIDE)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .sel_nxt(sel_nxt),
    .mc_nxt (mc_nxt),
    .tick   (tick)
  );

  pswallow_swallow #(.A_W(A_W)) u_swallow (
    .clk   (clk),
    .load  (boundary),
    .tick  (tick),
    .a_nxt (a_nxt),
    .mc_nxt(mc_nxt)
  );

  pswallow_main #(.B_W(B_W)) u_main (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .b_nxt (b_nxt),
    .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_pulse <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      div_pulse <= expire;
      cfg_err   <= cfg_err | (B_W'(act_a) > act_b);
    end
  end
endmodule

// File: rtl/pswallow_checker.sv
module pswallow_checker #(
  parameter int A_W      = 6,
  parameter int B_W      = 11,
  parameter int P_NARROW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           div_pulse,
  input logic           cfg_err,
  input logic [A_W-1:0] act_a,
  input logic [B_W-1:0] act_b
);
  localparam int CNT_W = B_W + A_W + 2;

  logic [CNT_W-1:0] since;
  logic             seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (div_pulse) begin
      since <= '0;
      seen  <= 1'b1;
    end else if (since != '1) begin
      since <= since + CNT_W'(1);
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) div_pulse |=> !div_pulse); // R2
  AST_PERIOD_MIN: assert property (@(posedge clk) disable iff (rst) (div_pulse && seen) |-> (since >= CNT_W'(P_NARROW - 1))); // R1
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (rst) (B_W'(act_a) > act_b) |=> cfg_err); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) cfg_err |=> cfg_err); // R5
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!div_pulse && !cfg_err)); // R6
endmodule

bind pswallow_divider pswallow_checker #(.A_W(A_W), .B_W(B_W), .P_NARROW(P_NARROW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .div_pulse(div_pulse),
  .cfg_err  (cfg_err),
  .act_a    (act_a),
  .act_b    (act_b)
);

// File: tb/test_pswallow_divider.sv
module test_pswallow_divider;
  localparam int LIMIT = 140000;

  typedef struct packed {
    logic        sel;
    logic [5:0]  a;
    logic [10:0] b;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 6'd0,  11'd1},
    '{1'b0, 6'd5,  11'd7},
    '{1'b1, 6'd3,  11'd3},
    '{1'b1, 6'd63, 11'd100},
    '{1'b0, 6'd63, 11'd63},
    '{1'b1, 6'd0,  11'd2},
    '{1'b1, 6'd10, 11'd300}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_wide = 1'b0;
  logic [5:0]  a_val = '0;
  logic [10:0] b_val = 11'd1;
  logic        div_pulse;
  logic        cfg_err;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  pswallow_divider i_pswallow_divider (
    .clk      (clk),
    .rst      (rst),
    .sel_wide (sel_wide),
    .a_val    (a_val),
    .b_val    (b_val),
    .div_pulse(div_pulse),
    .cfg_err  (cfg_err)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired actual=%0d expected<=200000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse && n < LIMIT);
    if (!div_pulse) n = -1;
  endtask

  task automatic do_reset(input logic s, input int a, input int b);
    @(negedge clk);
    rst = 1'b1;
    sel_wide = s;
    a_val = 6'(a);
    b_val = 11'(b);
    @(negedge clk);
    check("R6 pulse low in reset", int'(div_pulse), 0);
    check("R6 err low in reset", int'(cfg_err), 0);
    rst = 1'b0;
  endtask

  function automatic int expect_n(input logic s, input int a, input int b);
    int p = s ? 64 : 32;
    int bb = (b == 0) ? 1 : b;
    return bb * p + a;
  endfunction

  initial begin
    int n;
    // Vector table: first-pulse latency and one full period per setting.
    foreach (VECS[i]) begin
      do_reset(VECS[i].sel, int'(VECS[i].a), int'(VECS[i].b));
      wait_pulse(n);
      check("R6 first pulse latency", n, expect_n(VECS[i].sel, int'(VECS[i].a), int'(VECS[i].b)));
      wait_pulse(n);
      check("R1 R3 period", n, expect_n(VECS[i].sel, int'(VECS[i].a), int'(VECS[i].b)));
      check("R5 err stays low for valid setting", int'(cfg_err), 0);
    end

    // R2: pulse width of one cycle.
    do_reset(1'b0, 2, 3);
    wait_pulse(n);
    @(negedge clk);
    check("R2 pulse drops after one cycle", int'(div_pulse), 0);

    // R4: a change right after a pulse only affects the following period.
    do_reset(1'b0, 2, 3);
    wait_pulse(n);
    a_val = 6'd5;
    b_val = 11'd6;
    sel_wide = 1'b1;
    wait_pulse(n);
    check("R4 running period keeps old setting", n, 98);
    wait_pulse(n);
    check("R4 new setting after boundary", n, 6 * 64 + 5);

    // R4: a change in mid-period.
    do_reset(1'b1, 0, 2);
    wait_pulse(n);
    repeat (40) @(negedge clk);
    sel_wide = 1'b0;
    a_val = 6'd1;
    b_val = 11'd1;
    wait_pulse(n);
    check("R4 mid-period change deferred", n, 128 - 40);
    wait_pulse(n);
    check("R4 mid-period change applied", n, 33);

    // R7: B = 0 behaves like B = 1.
    do_reset(1'b1, 0, 0);
    wait_pulse(n);
    wait_pulse(n);
    check("R7 B zero period", n, 64);

    // R5: B < A flags and the output keeps a B*(P+1) period.
    do_reset(1'b0, 5, 3);
    @(negedge clk);
    check("R5 err raised", int'(cfg_err), 1);
    wait_pulse(n);
    wait_pulse(n);
    check("R5 bad setting period", n, 3 * 33);
    a_val = 6'd0;
    b_val = 11'd2;
    wait_pulse(n);
    wait_pulse(n);
    check("R5 valid period after bad", n, 64);
    check("R5 err sticky", int'(cfg_err), 1);
    do_reset(1'b0, 0, 2);
    @(negedge clk);
    check("R5 err cleared by reset", int'(cfg_err), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule